// File: doc/BRIEF.md
# Serial Row and Column Address Receiver

This block takes memory addresses that arrive one bit at a time on two serial lines, one for the row and one for the column, so that a memory device needs only a few pins for addressing. Each line has its own strobe. While a strobe is high, one bit is taken on every clock edge, most significant bit first. When the strobe drops, the word is kept only if exactly eight bits came in. Any other count throws the word away.

A row word that is kept goes through a range check before it reaches the row decoder. Words that name a row past the last one are refused and raise an error flag. A column word that is kept holds two parts. The upper two bits are an operation code and the lower six bits are the column index. The index goes straight to the column decoder. The operation code becomes a command for the memory controller: write from the input register, read to output A, read to output B, or refresh. The command comes with a one-cycle valid pulse, unless the most recent row word was refused.

Top module: `serial_addr_rx`

## Requirements
- R1: After synchronous reset, row_addr, col_index and cmd are 0, and cmd_valid and row_err are low.
- R2: While row_en is high, each clock edge takes one bit from row_sdi, first bit as bit 7. If exactly 8 bits arrived, row_addr shows the word on the second edge after the first edge that samples row_en low, provided that word is in range.
- R3: The column word is received in the same way on col_sdi and col_en. Its bits [5:0] appear on col_index on the first edge that samples col_en low.
- R4: A row or column word of fewer or more than 8 bits is discarded. row_addr, row_err, col_index and cmd keep their values, and cmd_valid stays low.
- R5: Column bits [7:6] select the command on cmd. The codes are: 00 write from the input register (cmd=0), 01 read to output A (cmd=1), 10 read to output B (cmd=2), 11 refresh of the latched row (cmd=3).
- R6: cmd_valid is high for exactly one cycle, one edge after col_index takes a new column word.
- R7: An accepted row word of 212 or more sets row_err and leaves row_addr unchanged. A word of 211 or less is latched and clears row_err, so row_addr never holds a value of 212 or more.
- R8: While row_err is high, a new column word still updates col_index, but no cmd_valid pulse is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_en | input | 1 | Row strobe; a bit is taken on each edge while high |
| row_sdi | input | 1 | Serial row data, MSB first |
| col_en | input | 1 | Column strobe; a bit is taken on each edge while high |
| col_sdi | input | 1 | Serial column data, MSB first |
| row_addr | output | 8 | Latched row address for the row decoder |
| row_err | output | 1 | Last accepted row word was out of range |
| col_index | output | 6 | Latched column index for the column decoder |
| cmd | output | 2 | Decoded operation code |
| cmd_valid | output | 1 | One-cycle pulse qualifying cmd |

## Verification
A bit counter that miscounts shows up one to two edges after the strobe falls. Either a good word fails to appear on row_addr or col_index, or a short or long word gets through. A shift register that takes bits in the wrong order shows up in the same cycle, as a wrong address value or a wrong cmd code. A range check or error flag in the wrong state shows up on row_err within two edges, and then in the presence or absence of the cmd_valid pulse for the next column word. All of these checks use strobe lengths of seven, eight and nine bits and rows on either side of the 212 limit.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int ROW_BITS   = 8;
    localparam int COL_BITS   = 8;
    localparam int INDEX_BITS = 6;
    localparam int ROW_LIMIT  = 212;

    typedef enum logic [1:0] {
        CMD_WRITE_IN = 2'd0,
        CMD_READ_A   = 2'd1,
        CMD_READ_B   = 2'd2,
        CMD_REFRESH  = 2'd3
    } cmd_e;

    function automatic cmd_e mode_to_cmd(input logic [1:0] mode);
        cmd_e c;
        case (mode)
            2'd0:    c = CMD_WRITE_IN;
            2'd1:    c = CMD_READ_A;
            2'd2:    c = CMD_READ_B;
            default: c = CMD_REFRESH;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sar_shift_in.sv
module sar_shift_in #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         sdi,
    output logic [W-1:0] word,
    output logic         done
);
    localparam int CW = $clog2(W + 2);
    localparam logic [CW-1:0] CNT_FULL = CW'(W);
    localparam logic [CW-1:0] CNT_SAT  = CW'(W + 1);

    logic [W-1:0]  shreg;
    logic [CW-1:0] cnt;
    logic          en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt   <= '0;
            en_q  <= 1'b0;
            word  <= '0;
            done  <= 1'b0;
        end else begin
            en_q <= en;
            done <= 1'b0;
            if (en) begin
                shreg <= {shreg[W-2:0], sdi};
                if (cnt != CNT_SAT)
                    cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
                if (en_q && cnt == CNT_FULL) begin
                    word <= shreg;
                    done <= 1'b1;
                end
            end
        end
    end

    // R4: a word is only handed on after the strobe has fallen
    a_r4_done_after_fall: assert property (@(posedge clk) disable iff (rst)
        done |-> !$past(en));

endmodule

// File: rtl/sar_row_check.sv
module sar_row_check
    import sar_pkg::*;
#(
    parameter int W     = ROW_BITS,
    parameter int LIMIT = ROW_LIMIT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         done,
    input  logic [W-1:0] word,
    output logic [W-1:0] row_addr,
    output logic         row_err
);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            row_addr <= '0;
            row_err  <= 1'b0;
        end else if (done) begin
            if (word < LIM) begin
                row_addr <= word;
                row_err  <= 1'b0;
            end else begin
                row_err  <= 1'b1;
            end
        end
    end

    // R7: the decoder never sees a row past the last one
    a_r7_row_in_range: assert property (@(posedge clk) disable iff (rst)
        row_addr < LIM);

endmodule

// File: rtl/sar_cmd_gen.sv
module sar_cmd_gen
    import sar_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       col_done,
    input  logic [1:0] mode,
    input  logic       row_err,
    output cmd_e       cmd,
    output logic       cmd_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd       <= CMD_WRITE_IN;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= col_done && !row_err;
            if (col_done)
                cmd <= mode_to_cmd(mode);
        end
    end

    // R6: pulse lasts a single cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R6: pulse follows a column latch by one edge
    a_r6_after_col: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(col_done));

    // R8: no command while the row error is up
    a_r8_blocked_by_err: assert property (@(posedge clk) disable iff (rst)
        (row_err && $stable(row_err)) |-> !cmd_valid);

endmodule

// File: rtl/serial_addr_rx.sv
module serial_addr_rx
    import sar_pkg::*;
#(
    parameter int ROW_W  = ROW_BITS,
    parameter int COL_W  = COL_BITS,
    parameter int IDX_W  = INDEX_BITS,
    parameter int ROWS   = ROW_LIMIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             row_en,
    input  logic             row_sdi,
    input  logic             col_en,
    input  logic             col_sdi,
    output logic [ROW_W-1:0] row_addr,
    output logic             row_err,
    output logic [IDX_W-1:0] col_index,
    output logic [1:0]       cmd,
    output logic             cmd_valid
);
    localparam int MODE_W = COL_W - IDX_W;

    logic [ROW_W-1:0] row_word;
    logic             row_done;
    logic [COL_W-1:0] col_word;
    logic             col_done;
    cmd_e             cmd_q;

    sar_shift_in #(.W(ROW_W)) u_row_shift (
        .clk(clk), .rst(rst), .en(row_en), .sdi(row_sdi),
        .word(row_word), .done(row_done)
    );

    sar_shift_in #(.W(COL_W)) u_col_shift (
        .clk(clk), .rst(rst), .en(col_en), .sdi(col_sdi),
        .word(col_word), .done(col_done)
    );

    sar_row_check #(.W(ROW_W), .LIMIT(ROWS)) u_row_check (
        .clk(clk), .rst(rst), .done(row_done), .word(row_word),
        .row_addr(row_addr), .row_err(row_err)
    );

    sar_cmd_gen u_cmd_gen (
        .clk(clk), .rst(rst), .col_done(col_done),
        .mode(col_word[COL_W-1 -: MODE_W]), .row_err(row_err),
        .cmd(cmd_q), .cmd_valid(cmd_valid)
    );

    assign col_index = col_word[IDX_W-1:0];
    assign cmd       = cmd_q;

endmodule

// File: tb/serial_addr_rx_bench.sv
`timescale 1ns/1ps
module serial_addr_rx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       row_en = 1'b0, row_sdi = 1'b0, col_en = 1'b0, col_sdi = 1'b0;
    logic [7:0] row_addr;
    logic       row_err;
    logic [5:0] col_index;
    logic [1:0] cmd;
    logic       cmd_valid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    serial_addr_rx u_serial_addr_rx (
        .clk(clk), .rst(rst), .row_en(row_en), .row_sdi(row_sdi),
        .col_en(col_en), .col_sdi(col_sdi), .row_addr(row_addr),
        .row_err(row_err), .col_index(col_index), .cmd(cmd),
        .cmd_valid(cmd_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic shift_word(input bit is_row, input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (is_row) begin row_en = 1'b1; row_sdi = (i < 8) ? v[7-i] : 1'b1; end
            else        begin col_en = 1'b1; col_sdi = (i < 8) ? v[7-i] : 1'b1; end
        end
        @(negedge clk);
        row_en = 1'b0;
        col_en = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(row_addr == 0 && col_index == 0 && cmd == 0, "R1 reset values",
            {row_addr, col_index, cmd}, 0);
        chk(!cmd_valid && !row_err, "R1 reset flags", {cmd_valid, row_err}, 0);
    endtask

    task automatic t_row(input logic [7:0] v);
        shift_word(1'b1, v, 8);
        @(negedge clk);
        @(negedge clk);
        chk(row_addr == v && !row_err, "R2 row latch", row_addr, v);
    endtask

    task automatic t_col(input logic [1:0] mode, input logic [5:0] idx, input bit expect_pulse);
        shift_word(1'b0, {mode, idx}, 8);
        @(negedge clk);
        chk(col_index == idx, "R3 column index", col_index, idx);
        chk(!cmd_valid, "R6 no early pulse", cmd_valid, 0);
        @(negedge clk);
        if (expect_pulse) begin
            chk(cmd_valid, "R6 pulse", cmd_valid, 1);
            chk(cmd == mode, "R5 cmd code", cmd, mode);
        end else begin
            chk(!cmd_valid, "R8 pulse blocked by row error", cmd_valid, 0);
        end
        @(negedge clk);
        chk(!cmd_valid, "R6 pulse one cycle", cmd_valid, 0);
    endtask

    task automatic t_discard(input bit is_row, input int n);
        logic [7:0] ra;
        logic [5:0] ci;
        logic [1:0] cm;
        logic       er;
        bit         pulsed;
        ra = row_addr; ci = col_index; cm = cmd; er = row_err;
        pulsed = 1'b0;
        shift_word(is_row, 8'h2B, n);
        repeat (3) begin
            @(negedge clk);
            if (cmd_valid) pulsed = 1'b1;
        end
        chk(row_addr == ra && row_err == er, "R4 row unchanged", row_addr, ra);
        chk(col_index == ci && cmd == cm, "R4 column unchanged", col_index, ci);
        chk(!pulsed, "R4 no pulse", pulsed, 0);
    endtask

    task automatic t_range();
        logic [7:0] prev;
        prev = row_addr;
        shift_word(1'b1, 8'd212, 8);
        @(negedge clk);
        @(negedge clk);
        chk(row_err, "R7 212 flagged", row_err, 1);
        chk(row_addr == prev, "R7 row kept on 212", row_addr, prev);
        t_col(2'b11, 6'd9, 1'b0);
        t_row(8'd211);
        chk(!row_err, "R7 211 clears error", row_err, 0);
        shift_word(1'b1, 8'd255, 8);
        @(negedge clk);
        @(negedge clk);
        chk(row_err && row_addr == 8'd211, "R7 255 flagged", row_addr, 211);
        t_row(8'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_row(8'hA5);
        t_row(8'h3C);
        t_col(2'b00, 6'h2A, 1'b1);
        t_col(2'b01, 6'h15, 1'b1);
        t_col(2'b10, 6'h3F, 1'b1);
        t_col(2'b11, 6'h01, 1'b1);
        t_discard(1'b1, 7);
        t_discard(1'b1, 9);
        t_discard(1'b0, 7);
        t_discard(1'b0, 9);
        t_range();
        t_col(2'b10, 6'h00, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule